// File: doc/BRIEF.md
# Register File with Pointer Pairs

This block is the working register file of a small 8-bit RISC core. It holds thirty-two byte-wide registers. Two read ports return operands combinationally, and one byte write port commits a result on the rising clock edge. The top six registers also act as three 16-bit address pointers, called X, Y and Z. The block computes the effective address for an indirect access. It also commits the pointer update that goes with that access, which can be a post-increment or a pre-decrement. A displacement form adds an offset to the address and leaves the pointer unchanged.

A separate word port adds or subtracts a small immediate on one of the four upper register pairs, treating the pair as a 16-bit value. A data-space decoder classifies a 16-bit data address. Low addresses hit the register window. The next 64 addresses form the I/O window, for which the decoder returns the I/O index. All other addresses fall outside both windows and go to memory.

Top module: `ptr_regfile`

## Requirements
- R1: While reset is low, every one of the 32 registers is zero, and both read ports therefore return 0x00.
- R2: A byte write with `wr_en_i` high stores `wr_data_i` into register `wr_addr_i` at the rising edge. The two read ports return any two registers, chosen independently, in the same cycle.
- R3: When a register is written and read in the same cycle, the read port returns the value it held before that edge.
- R4: The pointer views are X = R27:R26, Y = R29:R28 and Z = R31:R30, with the odd register holding the high byte. `ptr_sel_i` codes are 0 for X, 1 for Y and 2 or 3 for Z.
- R5: The `ptr_mode_i` codes work as follows, with `ea_o` valid in the same cycle and the pointer written back at the edge when `ptr_en_i` is high.
  - 0 is plain: the address is the pointer, and the pointer is unchanged.
  - 1 is post-increment: the address is the pointer, and the pointer then becomes pointer+1.
  - 2 is pre-decrement: the address is pointer-1, and the pointer becomes pointer-1.
  - 3 is displacement: the address is pointer+`ptr_disp_i` (0 to 63), and the pointer is unchanged. For X, code 3 acts as plain and ignores the displacement.
- R6: Pointer arithmetic and effective addresses wrap modulo 2^16.
- R7: The word port works on one register pair, selected by `word_sel_i`: 0 for R25:R24, 1 for R27:R26, 2 for R29:R28 and 3 for R31:R30. It adds `word_imm_i` (0 to 63), or subtracts it when `word_sub_i` is high. `word_res_o` shows the result in the same cycle, and the pair takes that result at the edge when `word_en_i` is high. The result wraps modulo 2^16.
- R8: When the writers overlap in one cycle, a pointer update beats both the word port and the byte port on the bytes it writes. The word port beats the byte port. Writers that touch different registers all take effect.
- R9: For data addresses 0x00 to 0x1F, `ds_is_reg_o` is high. For 0x20 to 0x5F, `ds_is_io_o` is high and `ds_io_idx_o` equals the address minus 0x20. For any other address, both flags are low and the index is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ra_addr_i | input | 5 | Read port A register index |
| ra_data_o | output | 8 | Read port A data |
| rb_addr_i | input | 5 | Read port B register index |
| rb_data_o | output | 8 | Read port B data |
| wr_en_i | input | 1 | Byte write enable |
| wr_addr_i | input | 5 | Byte write register index |
| wr_data_i | input | 8 | Byte write data |
| ptr_en_i | input | 1 | Indirect access active; commits pointer update |
| ptr_sel_i | input | 2 | Pointer select (0 X, 1 Y, 2/3 Z) |
| ptr_mode_i | input | 2 | Addressing mode (0 plain, 1 post-inc, 2 pre-dec, 3 displacement) |
| ptr_disp_i | input | 6 | Displacement |
| ea_o | output | 16 | Effective address |
| ptr_x_o | output | 16 | X pointer view |
| ptr_y_o | output | 16 | Y pointer view |
| ptr_z_o | output | 16 | Z pointer view |
| word_en_i | input | 1 | Word add/subtract commit |
| word_sel_i | input | 2 | Word pair select |
| word_sub_i | input | 1 | Subtract instead of add |
| word_imm_i | input | 6 | Word immediate |
| word_res_o | output | 16 | Word operation result |
| ds_addr_i | input | 16 | Data-space address to classify |
| ds_is_reg_o | output | 1 | Address is in the register window |
| ds_is_io_o | output | 1 | Address is in the I/O window |
| ds_io_idx_o | output | 6 | I/O index for the address |

## Verification
Two functions can land in the same cycle: a pointer update and an ordinary byte write or word operation that targets a byte of the same pointer. The bench provokes this in three ways:
- a post-increment of X is issued together with a byte write into R26;
- a post-increment of Z is issued together with a word add on R31:R30;
- a post-increment of X is issued together with a word add on the disjoint pair R25:R24.

The result is judged after the edge by reading the pointer view and the affected registers through the read ports. In the first two cases only the incremented pointer should remain. In the third case both updates should be visible.

// File: rtl/rf_pkg.sv
package rf_pkg;
  typedef enum logic [1:0] {
    AM_PLAIN   = 2'd0,
    AM_POSTINC = 2'd1,
    AM_PREDEC  = 2'd2,
    AM_DISP    = 2'd3
  } am_e;
endpackage

// File: rtl/rf_storage.sv
module rf_storage #(
  parameter int NREG = 32,
  parameter int DW   = 8,
  localparam int RA_W   = $clog2(NREG),
  localparam int PAIR_W = RA_W - 1
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       wr_en_i,
  input  logic [RA_W-1:0]            wr_addr_i,
  input  logic [DW-1:0]              wr_data_i,
  input  logic                       pwa_en_i,
  input  logic [PAIR_W-1:0]          pwa_idx_i,
  input  logic [2*DW-1:0]            pwa_data_i,
  input  logic                       pwb_en_i,
  input  logic [PAIR_W-1:0]          pwb_idx_i,
  input  logic [2*DW-1:0]            pwb_data_i,
  input  logic [RA_W-1:0]            ra_addr_i,
  input  logic [RA_W-1:0]            rb_addr_i,
  output logic [DW-1:0]              ra_data_o,
  output logic [DW-1:0]              rb_data_o,
  output logic [NREG-1:0][DW-1:0]    regs_o
);
  logic [NREG-1:0][DW-1:0] regs_q;

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    // pointer port > word port > byte port
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        regs_q[g] <= '0;
      else if (pwa_en_i && pwa_idx_i == PAIR_W'(g / 2))
        regs_q[g] <= pwa_data_i[(g % 2)*DW +: DW];
      else if (pwb_en_i && pwb_idx_i == PAIR_W'(g / 2))
        regs_q[g] <= pwb_data_i[(g % 2)*DW +: DW];
      else if (wr_en_i && wr_addr_i == RA_W'(g))
        regs_q[g] <= wr_data_i;
    end
  end

  assign ra_data_o = regs_q[ra_addr_i];
  assign rb_data_o = regs_q[rb_addr_i];
  assign regs_o    = regs_q;
endmodule

// File: rtl/rf_ptr_unit.sv
module rf_ptr_unit
  import rf_pkg::*;
#(
  parameter int AW     = 16,
  parameter int DISP_W = 6
) (
  input  logic [AW-1:0]     ptr_i,
  input  am_e               mode_i,
  input  logic              disp_ok_i,
  input  logic [DISP_W-1:0] disp_i,
  output logic [AW-1:0]     ea_o,
  output logic [AW-1:0]     nxt_o,
  output logic              upd_o
);
  logic [AW-1:0] inc, dec;
  assign inc = ptr_i + AW'(1);
  assign dec = ptr_i - AW'(1);

  always_comb begin
    ea_o  = ptr_i;
    nxt_o = ptr_i;
    upd_o = 1'b0;
    unique case (mode_i)
      AM_POSTINC: begin nxt_o = inc; upd_o = 1'b1; end
      AM_PREDEC:  begin ea_o = dec; nxt_o = dec; upd_o = 1'b1; end
      AM_DISP:    if (disp_ok_i) ea_o = ptr_i + AW'(disp_i);
      default:    ;
    endcase
  end
endmodule

// File: rtl/rf_word_alu.sv
module rf_word_alu #(
  parameter int AW    = 16,
  parameter int IMM_W = 6
) (
  input  logic [AW-1:0]    val_i,
  input  logic [IMM_W-1:0] imm_i,
  input  logic             sub_i,
  output logic [AW-1:0]    res_o
);
  assign res_o = sub_i ? (val_i - AW'(imm_i)) : (val_i + AW'(imm_i));
endmodule

// File: rtl/rf_ds_decode.sv
module rf_ds_decode #(
  parameter int AW      = 16,
  parameter int REG_WIN = 32,
  parameter int IO_WIN  = 64,
  localparam int IO_W   = $clog2(IO_WIN)
) (
  input  logic [AW-1:0]   addr_i,
  output logic            is_reg_o,
  output logic            is_io_o,
  output logic [IO_W-1:0] io_idx_o
);
  localparam logic [AW-1:0] IO_LO = AW'(REG_WIN);
  localparam logic [AW-1:0] IO_HI = AW'(REG_WIN + IO_WIN);

  logic [AW-1:0] rel;
  assign rel      = addr_i - IO_LO;
  assign is_reg_o = addr_i < IO_LO;
  assign is_io_o  = (addr_i >= IO_LO) && (addr_i < IO_HI);
  assign io_idx_o = is_io_o ? rel[IO_W-1:0] : '0;
endmodule

// File: rtl/ptr_regfile.sv
module ptr_regfile
  import rf_pkg::*;
#(
  parameter int NREG    = 32,
  parameter int DW      = 8,
  parameter int DISP_W  = 6,
  parameter int IMM_W   = 6,
  parameter int REG_WIN = 32,
  parameter int IO_WIN  = 64,
  localparam int RA_W   = $clog2(NREG),
  localparam int AW     = 2 * DW,
  localparam int IO_W   = $clog2(IO_WIN)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [RA_W-1:0]   ra_addr_i,
  output logic [DW-1:0]     ra_data_o,
  input  logic [RA_W-1:0]   rb_addr_i,
  output logic [DW-1:0]     rb_data_o,
  input  logic              wr_en_i,
  input  logic [RA_W-1:0]   wr_addr_i,
  input  logic [DW-1:0]     wr_data_i,
  input  logic              ptr_en_i,
  input  logic [1:0]        ptr_sel_i,
  input  logic [1:0]        ptr_mode_i,
  input  logic [DISP_W-1:0] ptr_disp_i,
  output logic [AW-1:0]     ea_o,
  output logic [AW-1:0]     ptr_x_o,
  output logic [AW-1:0]     ptr_y_o,
  output logic [AW-1:0]     ptr_z_o,
  input  logic              word_en_i,
  input  logic [1:0]        word_sel_i,
  input  logic              word_sub_i,
  input  logic [IMM_W-1:0]  word_imm_i,
  output logic [AW-1:0]     word_res_o,
  input  logic [AW-1:0]     ds_addr_i,
  output logic              ds_is_reg_o,
  output logic              ds_is_io_o,
  output logic [IO_W-1:0]   ds_io_idx_o
);
  localparam int PAIR_W    = RA_W - 1;
  localparam int NPTR      = 3;
  localparam int PTR_BASE  = NREG - 2 * NPTR;
  localparam int WORD_BASE = NREG - 8;

  logic [NREG-1:0][DW-1:0] regs;
  logic [NPTR-1:0][AW-1:0] ptr_w;
  logic [1:0]              ptr_idx;
  logic [AW-1:0]           cur_ptr, nxt_ptr;
  logic                    ptr_upd;
  logic [RA_W-1:0]         word_lo;
  logic [AW-1:0]           word_val;

  for (genvar p = 0; p < NPTR; p++) begin : g_ptr
    assign ptr_w[p] = {regs[PTR_BASE + 2*p + 1], regs[PTR_BASE + 2*p]};
  end
  assign ptr_x_o = ptr_w[0];
  assign ptr_y_o = ptr_w[1];
  assign ptr_z_o = ptr_w[2];

  assign ptr_idx = (ptr_sel_i == 2'd3) ? 2'd2 : ptr_sel_i;
  assign cur_ptr = ptr_w[ptr_idx];

  rf_ptr_unit #(.AW(AW), .DISP_W(DISP_W)) u_ptr (
    .ptr_i     (cur_ptr),
    .mode_i    (am_e'(ptr_mode_i)),
    .disp_ok_i (ptr_idx != 2'd0),
    .disp_i    (ptr_disp_i),
    .ea_o      (ea_o),
    .nxt_o     (nxt_ptr),
    .upd_o     (ptr_upd)
  );

  assign word_lo  = RA_W'(WORD_BASE) + RA_W'({word_sel_i, 1'b0});
  assign word_val = {regs[word_lo | RA_W'(1)], regs[word_lo]};

  rf_word_alu #(.AW(AW), .IMM_W(IMM_W)) u_word (
    .val_i (word_val),
    .imm_i (word_imm_i),
    .sub_i (word_sub_i),
    .res_o (word_res_o)
  );

  rf_storage #(.NREG(NREG), .DW(DW)) u_store (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .wr_addr_i  (wr_addr_i),
    .wr_data_i  (wr_data_i),
    .pwa_en_i   (ptr_en_i && ptr_upd),
    .pwa_idx_i  (PAIR_W'(PTR_BASE / 2) + PAIR_W'(ptr_idx)),
    .pwa_data_i (nxt_ptr),
    .pwb_en_i   (word_en_i),
    .pwb_idx_i  (word_lo[RA_W-1:1]),
    .pwb_data_i (word_res_o),
    .ra_addr_i  (ra_addr_i),
    .rb_addr_i  (rb_addr_i),
    .ra_data_o  (ra_data_o),
    .rb_data_o  (rb_data_o),
    .regs_o     (regs)
  );

  rf_ds_decode #(.AW(AW), .REG_WIN(REG_WIN), .IO_WIN(IO_WIN)) u_ds (
    .addr_i   (ds_addr_i),
    .is_reg_o (ds_is_reg_o),
    .is_io_o  (ds_is_io_o),
    .io_idx_o (ds_io_idx_o)
  );
endmodule

// File: rtl/ptr_regfile_chk.sv
module ptr_regfile_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [4:0]  ra_addr_i,
  input logic [7:0]  ra_data_o,
  input logic [7:0]  rb_data_o,
  input logic        wr_en_i,
  input logic [4:0]  wr_addr_i,
  input logic [7:0]  wr_data_i,
  input logic        ptr_en_i,
  input logic [1:0]  ptr_sel_i,
  input logic [1:0]  ptr_mode_i,
  input logic        word_en_i,
  input logic [15:0] ea_o,
  input logic [15:0] ptr_x_o,
  input logic [15:0] ptr_y_o,
  input logic [15:0] ptr_z_o,
  input logic [15:0] ds_addr_i,
  input logic        ds_is_reg_o,
  input logic        ds_is_io_o,
  input logic [5:0]  ds_io_idx_o
);
  always @(negedge clk_i)
    if (!rst_ni) a_r1_reset_zero: assert (ra_data_o == 8'h00 && rb_data_o == 8'h00);

  a_r2_byte_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && !ptr_en_i && !word_en_i |=>
      (ra_addr_i != $past(wr_addr_i)) || (ra_data_o == $past(wr_data_i)));

  a_r5_predec_ea: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr_en_i && ptr_mode_i == 2'd2 && ptr_sel_i == 2'd1 |-> ea_o == ptr_y_o - 16'd1);

  a_r5_postinc_z: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr_en_i && ptr_mode_i == 2'd1 && ptr_sel_i[1] |=> ptr_z_o == $past(ptr_z_o) + 16'd1);

  a_r5_disp_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr_en_i && ptr_mode_i == 2'd3 && ptr_sel_i == 2'd1 && !wr_en_i && !word_en_i
      |=> $stable(ptr_y_o));

  a_r8_ptr_beats_byte: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr_en_i && ptr_mode_i == 2'd1 && ptr_sel_i == 2'd0 && wr_en_i && wr_addr_i[4:1] == 4'd13
      |=> ptr_x_o == $past(ptr_x_o) + 16'd1);

  a_r9_windows_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ds_is_reg_o && ds_is_io_o));

  a_r9_io_index: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ds_is_io_o |-> (16'(ds_io_idx_o) + 16'h0020) == ds_addr_i);
endmodule

bind ptr_regfile ptr_regfile_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ra_addr_i   (ra_addr_i),
  .ra_data_o   (ra_data_o),
  .rb_data_o   (rb_data_o),
  .wr_en_i     (wr_en_i),
  .wr_addr_i   (wr_addr_i),
  .wr_data_i   (wr_data_i),
  .ptr_en_i    (ptr_en_i),
  .ptr_sel_i   (ptr_sel_i),
  .ptr_mode_i  (ptr_mode_i),
  .word_en_i   (word_en_i),
  .ea_o        (ea_o),
  .ptr_x_o     (ptr_x_o),
  .ptr_y_o     (ptr_y_o),
  .ptr_z_o     (ptr_z_o),
  .ds_addr_i   (ds_addr_i),
  .ds_is_reg_o (ds_is_reg_o),
  .ds_is_io_o  (ds_is_io_o),
  .ds_io_idx_o (ds_io_idx_o)
);

// File: tb/tb_ptr_regfile.sv
`timescale 1ns/1ps
module tb_ptr_regfile;
  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic [4:0]  ra_addr_i, rb_addr_i, wr_addr_i;
  logic [7:0]  ra_data_o, rb_data_o, wr_data_i;
  logic        wr_en_i, ptr_en_i, word_en_i, word_sub_i;
  logic [1:0]  ptr_sel_i, ptr_mode_i, word_sel_i;
  logic [5:0]  ptr_disp_i, word_imm_i, ds_io_idx_o;
  logic [15:0] ea_o, ptr_x_o, ptr_y_o, ptr_z_o, word_res_o, ds_addr_i;
  logic        ds_is_reg_o, ds_is_io_o;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk_i = ~clk_i;

  ptr_regfile dut (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    wr_en_i = 0; ptr_en_i = 0; word_en_i = 0; word_sub_i = 0;
    ptr_sel_i = 0; ptr_mode_i = 0; ptr_disp_i = 0; word_sel_i = 0; word_imm_i = 0;
  endtask

  task automatic step();
    @(posedge clk_i); @(negedge clk_i); idle();
  endtask

  task automatic wr(logic [4:0] a, logic [7:0] d);
    wr_en_i = 1; wr_addr_i = a; wr_data_i = d; step();
  endtask

  task automatic rd(logic [4:0] a, string req, logic [7:0] exp);
    ra_addr_i = a; #0.5; chk(req, ra_data_o, exp);
  endtask

  task automatic t_reset();
    for (int i = 0; i < 32; i++) begin
      ra_addr_i = 5'(i); rb_addr_i = 5'(31 - i); #0.1;
      chk("R1 porta", ra_data_o, 0); chk("R1 portb", rb_data_o, 0);
    end
  endtask

  task automatic t_byte();
    wr(5'd3, 8'h5A); wr(5'd17, 8'hC3); wr(5'd0, 8'h81);
    ra_addr_i = 3; rb_addr_i = 17; #0.5;
    chk("R2 a", ra_data_o, 8'h5A); chk("R2 b", rb_data_o, 8'hC3);
    ra_addr_i = 0; rb_addr_i = 3; #0.5;
    chk("R2 a2", ra_data_o, 8'h81); chk("R2 b2", rb_data_o, 8'h5A);
  endtask

  task automatic t_old();
    wr(5'd5, 8'hA5);
    wr_en_i = 1; wr_addr_i = 5; wr_data_i = 8'h3C; ra_addr_i = 5; rb_addr_i = 5; #0.5;
    chk("R3 old a", ra_data_o, 8'hA5); chk("R3 old b", rb_data_o, 8'hA5);
    step(); #0.5;
    chk("R3 new", ra_data_o, 8'h3C);
  endtask

  task automatic t_view();
    wr(26, 8'h34); wr(27, 8'h12); wr(28, 8'h78); wr(29, 8'h56); wr(30, 8'hBC); wr(31, 8'h9A);
    #0.5;
    chk("R4 X", ptr_x_o, 16'h1234); chk("R4 Y", ptr_y_o, 16'h5678); chk("R4 Z", ptr_z_o, 16'h9ABC);
  endtask

  task automatic acc(logic [1:0] s, logic [1:0] m, logic [5:0] q);
    ptr_en_i = 1; ptr_sel_i = s; ptr_mode_i = m; ptr_disp_i = q; #0.5;
  endtask

  task automatic t_modes();
    acc(0, 0, 0); chk("R5 plain ea", ea_o, 16'h1234); step(); chk("R5 plain hold", ptr_x_o, 16'h1234);
    acc(0, 1, 0); chk("R5 post ea", ea_o, 16'h1234); step(); chk("R5 post X", ptr_x_o, 16'h1235);
    rd(26, "R5 post lo byte", 8'h35);
    acc(1, 2, 0); chk("R5 pre ea", ea_o, 16'h5677); step(); chk("R5 pre Y", ptr_y_o, 16'h5677);
    acc(2, 3, 6'd10); chk("R5 disp Z ea", ea_o, 16'h9AC6); step(); chk("R5 disp Z hold", ptr_z_o, 16'h9ABC);
    acc(3, 1, 0); chk("R5 sel3 is Z", ea_o, 16'h9ABC); step(); chk("R5 sel3 Z", ptr_z_o, 16'h9ABD);
    acc(0, 3, 6'd20); chk("R5 X disp ignored", ea_o, 16'h1235); step(); chk("R5 X disp hold", ptr_x_o, 16'h1235);
  endtask

  task automatic t_wrap();
    wr(30, 8'hFF); wr(31, 8'hFF);
    acc(2, 1, 0); step(); chk("R6 Z wrap up", ptr_z_o, 16'h0000);
    wr(28, 8'h00); wr(29, 8'h00);
    acc(1, 2, 0); chk("R6 pre ea wrap", ea_o, 16'hFFFF); step(); chk("R6 Y wrap down", ptr_y_o, 16'hFFFF);
    wr(28, 8'hF0);
    acc(1, 3, 6'd63); chk("R6 disp wrap", ea_o, 16'h002F); step();
  endtask

  task automatic t_word();
    wr(24, 8'hFF); wr(25, 8'h00);
    word_en_i = 1; word_sel_i = 0; word_imm_i = 1; #0.5;
    chk("R7 add res", word_res_o, 16'h0100); step();
    rd(24, "R7 lo", 8'h00); rd(25, "R7 hi", 8'h01);
    word_en_i = 1; word_sel_i = 0; word_sub_i = 1; word_imm_i = 2; step();
    rd(24, "R7 sub lo", 8'hFE); rd(25, "R7 sub hi", 8'h00);
    wr(26, 8'h00); wr(27, 8'h00);
    word_en_i = 1; word_sel_i = 1; word_sub_i = 1; word_imm_i = 6'd63; #0.5;
    chk("R7 sub wrap", word_res_o, 16'hFFC1); step(); chk("R7 pair X", ptr_x_o, 16'hFFC1);
  endtask

  task automatic t_collide();
    wr(26, 8'h10); wr(27, 8'h20);
    acc(0, 1, 0); wr_en_i = 1; wr_addr_i = 26; wr_data_i = 8'hEE; step();
    chk("R8 ptr beats byte", ptr_x_o, 16'h2011);
    wr(30, 8'h40); wr(31, 8'h00);
    acc(2, 1, 0); word_en_i = 1; word_sel_i = 3; word_imm_i = 5; step();
    chk("R8 ptr beats word", ptr_z_o, 16'h0041);
    wr(24, 8'h00); wr(25, 8'h00);
    acc(0, 1, 0); word_en_i = 1; word_sel_i = 0; word_imm_i = 7; step();
    chk("R8 disjoint ptr", ptr_x_o, 16'h2012);
    rd(24, "R8 disjoint word", 8'h07);
    wr(8, 8'h11);
    word_en_i = 1; word_sel_i = 0; word_imm_i = 1; wr_en_i = 1; wr_addr_i = 24; wr_data_i = 8'h99; step();
    rd(24, "R8 word beats byte", 8'h08);
  endtask

  task automatic ds(logic [15:0] a, logic r, logic io, logic [5:0] idx);
    ds_addr_i = a; #0.5;
    chk("R9 reg", ds_is_reg_o, r); chk("R9 io", ds_is_io_o, io); chk("R9 idx", ds_io_idx_o, idx);
  endtask

  task automatic t_ds();
    ds(16'h0000, 1, 0, 0); ds(16'h001F, 1, 0, 0); ds(16'h0020, 0, 1, 0);
    ds(16'h0035, 0, 1, 6'h15); ds(16'h005F, 0, 1, 6'h3F); ds(16'h0060, 0, 0, 0); ds(16'hFFFF, 0, 0, 0);
    @(negedge clk_i);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #1000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    idle(); ra_addr_i = 0; rb_addr_i = 0; wr_addr_i = 0; wr_data_i = 0; ds_addr_i = 0;
    rst_ni = 1; #1 rst_ni = 0;
    @(negedge clk_i); t_reset();
    @(negedge clk_i); @(negedge clk_i); rst_ni = 1; @(negedge clk_i);
    t_byte(); t_old(); t_view(); t_modes(); t_wrap(); t_word(); t_collide(); t_ds();
    finish_run();
  end
endmodule